// File: doc/BRIEF.md
# Latency-Delayed Instruction Staging Buffer

This block sits between an instruction producer (fetch/decode) and an instruction consumer (dispatch). It adds a fixed number of cycles of delay, set by a parameter. Each entry holds a sequence number and the number of destination registers the instruction needs.

Accepted entries first wait in a staging queue. A one-bit-per-cycle delay line records each insertion. When a recorded insertion reaches the end of the line, the oldest staging entry moves into a ready queue. The consumer can only take entries from the ready queue.

A squash names a sequence number. It trims every younger entry from the tail of both queues and gives the destination-register credits of those entries back. A flush empties the block and returns every credit. The block also keeps a free-register credit counter:
- an accepted push takes credits from the counter;
- squash, flush and the retire input give credits back.

Top module: `lsb_stage_buf`

## Requirements
- R1: After reset the block holds no entries, `occupancy` is 0, `popValid` is low, `pushReady` is high, and `freeCredits` equals `NUM_REGS`.
- R2: An entry accepted in cycle c (`pushValid && pushReady` at the clock edge closing c) raises `popValid` no earlier than cycle c+`LATENCY`. It is offered there, if it is the oldest entry held. `popValid` stays low while only immature entries are held.
- R3: Entries leave in the order they were accepted. While `popValid` is high, `popSeq`/`popDregs` show the oldest entry. It is removed at the edge where `popReq` is high.
- R4: `occupancy` never exceeds `MAX_OCC`. At `MAX_OCC`, `pushReady` is low and a push that is offered has no effect.
- R5: A squash with sequence number S removes, from the tail of the held sequence, every entry whose sequence number is greater than S. It stops at the first entry that is not greater than S. The surviving entries keep their original ready cycle.
- R6: Every entry removed by a squash or a flush adds its destination-register count to `freeCredits` at that edge. It is also removed from `occupancy`.
- R7: A flush empties both queues and any pending delay-line records. When `flush` and `squashValid` are high together, the flush takes precedence.
- R8: In any cycle with `squashValid` or `flush` high, `pushReady` and `popValid` are low. No push or pop takes place in that cycle.
- R9: An accepted push subtracts `pushDregs` from `freeCredits`. `retireRegs` adds to it at every edge. `pushReady` is low when `freeCredits` is less than `pushDregs`.
- R10: `occupancy` equals the number of entries held in staging and ready together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Producer offers an entry |
| pushSeq | input | SEQ_W | Sequence number of the offered entry |
| pushDregs | input | DREG_W | Destination-register count of the offered entry |
| pushReady | output | 1 | Entry will be accepted this cycle |
| popReq | input | 1 | Consumer takes the offered entry |
| popValid | output | 1 | A matured entry is offered |
| popSeq | output | SEQ_W | Sequence number of the offered entry |
| popDregs | output | DREG_W | Destination-register count of the offered entry |
| squashValid | input | 1 | Remove entries younger than squashSeq |
| squashSeq | input | SEQ_W | Squash boundary sequence number |
| flush | input | 1 | Remove everything |
| retireRegs | input | CREDIT_W | Credits returned by retirement this cycle |
| freeCredits | output | CREDIT_W | Free destination-register credits |
| occupancy | output | OCC_W | Entries held in both queues |

## Verification
The checks take three things for granted about the inputs:
- Sequence numbers offered on `pushSeq` strictly increase and never wrap.
- `retireRegs` never returns more credits than have been popped and not yet returned. As a result, `freeCredits` never rises above `NUM_REGS`.
- `pushSeq` and `pushDregs` hold their values during a cycle.

The stimulus enforces these rules:
- It takes each new sequence number from a running counter that only moves forward.
- It draws the retire amount from the popped-but-unreturned total that it tracks.
- It chooses squash boundaries from the sequence numbers it knows are currently held, sometimes offset by one.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  // Per-cycle strobes issued by the control toward the datapath.
  typedef struct packed {
    logic push;    // accepted producer entry
    logic pop;     // consumer takes the ready head
    logic xfer;    // staging head moves to the ready tail
    logic squash;  // trim younger entries from both tails
    logic flush;   // drop everything
  } lsbStrobes_t;

endpackage

// File: rtl/lsb_queue.sv
module lsb_queue #(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int DREG_W   = 2,
  parameter int CREDIT_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [SEQ_W-1:0]             wrSeq,
  input  logic [DREG_W-1:0]            wrDregs,
  input  logic                         rdEn,
  input  logic                         cutEn,
  input  logic                         cutAll,
  input  logic [SEQ_W-1:0]             cutSeq,
  output logic [SEQ_W-1:0]             headSeq,
  output logic [DREG_W-1:0]            headDregs,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [CREDIT_W-1:0]          cutCredit
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0]  seqMem  [DEPTH];
  logic [DREG_W-1:0] dregMem [DEPTH];
  logic [PTR_W-1:0]  headPtr;
  logic [CNT_W-1:0]  cnt;

  logic [CNT_W-1:0]    removed;
  logic [CNT_W-1:0]    baseCnt;
  logic [CREDIT_W-1:0] credit;
  logic [PTR_W-1:0]    scanIdx;
  logic [PTR_W-1:0]    wrIdx;
  logic                cutting;

  // Walk from the tail toward the head, removing younger entries until
  // the first one that is not younger than the boundary.
  always_comb begin
    cutting = cutEn;
    removed = '0;
    credit  = '0;
    scanIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt) begin
        scanIdx = headPtr + PTR_W'(i);
        if (cutting && (cutAll || (seqMem[scanIdx] > cutSeq))) begin
          credit  = credit + CREDIT_W'(dregMem[scanIdx]);
          removed = removed + CNT_W'(1);
        end else begin
          cutting = 1'b0;
        end
      end
    end
  end

  assign baseCnt = cutEn ? (cnt - removed) : cnt;
  assign wrIdx   = headPtr + PTR_W'(baseCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      cnt     <= '0;
    end else begin
      headPtr <= headPtr + PTR_W'(rdEn);
      cnt     <= baseCnt - CNT_W'(rdEn) + CNT_W'(wrEn);
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      seqMem[wrIdx]  <= wrSeq;
      dregMem[wrIdx] <= wrDregs;
    end
  end

  assign headSeq   = seqMem[headPtr];
  assign headDregs = dregMem[headPtr];
  assign count     = cnt;
  assign cutCredit = credit;

endmodule

// File: rtl/lsb_data.sv
module lsb_data
  import lsb_pkg::*;
#(
  parameter int LATENCY  = 3,
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int DREG_W   = 2,
  parameter int CREDIT_W = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  lsbStrobes_t                 strobes,
  input  logic [SEQ_W-1:0]            pushSeq,
  input  logic [DREG_W-1:0]           pushDregs,
  input  logic [SEQ_W-1:0]            squashSeq,
  output logic [SEQ_W-1:0]            popSeq,
  output logic [DREG_W-1:0]           popDregs,
  output logic [$clog2(DEPTH+1)-1:0]  stgCount,
  output logic [$clog2(DEPTH+1)-1:0]  rdyCount,
  output logic [CREDIT_W-1:0]         retCredit
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                cutEn;
  logic [SEQ_W-1:0]    rdyWrSeq;
  logic [DREG_W-1:0]   rdyWrDregs;
  logic                rdyWrEn;
  logic [CREDIT_W-1:0] stgCredit;
  logic [CREDIT_W-1:0] rdyCredit;

  assign cutEn = strobes.squash | strobes.flush;

  generate
    if (LATENCY == 1) begin : gDirect
      // A one-cycle delay lands each accepted entry straight in ready.
      assign rdyWrEn    = strobes.push;
      assign rdyWrSeq   = pushSeq;
      assign rdyWrDregs = pushDregs;
      assign stgCount   = '0;
      assign stgCredit  = '0;
    end else begin : gStaged
      logic [SEQ_W-1:0]  stgHeadSeq;
      logic [DREG_W-1:0] stgHeadDregs;
      logic [CNT_W-1:0]  stgCnt;

      lsb_queue #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .DREG_W(DREG_W), .CREDIT_W(CREDIT_W)
      ) u_stage (
        .clk(clk), .rstN(rstN),
        .wrEn(strobes.push), .wrSeq(pushSeq), .wrDregs(pushDregs),
        .rdEn(strobes.xfer),
        .cutEn(cutEn), .cutAll(strobes.flush), .cutSeq(squashSeq),
        .headSeq(stgHeadSeq), .headDregs(stgHeadDregs),
        .count(stgCnt), .cutCredit(stgCredit)
      );

      assign rdyWrEn    = strobes.xfer;
      assign rdyWrSeq   = stgHeadSeq;
      assign rdyWrDregs = stgHeadDregs;
      assign stgCount   = stgCnt;
    end
  endgenerate

  lsb_queue #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .DREG_W(DREG_W), .CREDIT_W(CREDIT_W)
  ) u_ready (
    .clk(clk), .rstN(rstN),
    .wrEn(rdyWrEn), .wrSeq(rdyWrSeq), .wrDregs(rdyWrDregs),
    .rdEn(strobes.pop),
    .cutEn(cutEn), .cutAll(strobes.flush), .cutSeq(squashSeq),
    .headSeq(popSeq), .headDregs(popDregs),
    .count(rdyCount), .cutCredit(rdyCredit)
  );

  assign retCredit = stgCredit + rdyCredit;

endmodule

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
#(
  parameter int LATENCY  = 3,
  parameter int MAX_OCC  = 8,
  parameter int SEQ_W    = 16,
  parameter int DREG_W   = 2,
  parameter int NUM_REGS = 32,
  parameter int CREDIT_W = 6,
  parameter int OCC_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [SEQ_W-1:0]    pushSeq,
  input  logic [DREG_W-1:0]   pushDregs,
  input  logic                popReq,
  input  logic                squashValid,
  input  logic [SEQ_W-1:0]    squashSeq,
  input  logic                flush,
  input  logic [CREDIT_W-1:0] retireRegs,
  input  logic [OCC_W-1:0]    stgCount,
  input  logic [OCC_W-1:0]    rdyCount,
  input  logic [CREDIT_W-1:0] retCredit,
  output lsbStrobes_t         strobes,
  output logic                pushReady,
  output logic                popValid,
  output logic [OCC_W-1:0]    occupancy,
  output logic [CREDIT_W-1:0] freeCredits
);

  logic                busy;
  logic [OCC_W-1:0]    occ;
  logic [CREDIT_W-1:0] credits;
  logic                xferGo;

  assign busy      = squashValid | flush;
  assign occ       = stgCount + rdyCount;
  assign pushReady = !busy && (occ < OCC_W'(MAX_OCC)) &&
                     (credits >= CREDIT_W'(pushDregs));
  assign popValid  = !busy && (rdyCount != '0);

  assign strobes.push   = pushValid & pushReady;
  assign strobes.pop    = popReq & popValid;
  assign strobes.xfer   = xferGo;
  assign strobes.squash = squashValid & ~flush;
  assign strobes.flush  = flush;

  generate
    if (LATENCY == 1) begin : gNoLine
      logic unusedSeq;
      assign unusedSeq = ^{pushSeq, squashSeq, stgCount};
      assign xferGo    = 1'b0;
    end else begin : gLine
      // One bit per cycle of delay, tagged with the sequence number of
      // the insertion so a squash can cancel records of removed entries.
      localparam int DL = LATENCY - 1;
      logic [DL-1:0]    dlBit;
      logic [SEQ_W-1:0] dlTag [DL];
      logic [DL-1:0]    dlKill;

      always_comb begin
        for (int i = 0; i < DL; i++) begin
          dlKill[i] = flush || (squashValid && (dlTag[i] > squashSeq));
        end
      end

      assign xferGo = dlBit[DL-1] && !dlKill[DL-1] && (stgCount != '0);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dlBit <= '0;
        end else begin
          dlBit[0] <= strobes.push;
          for (int i = 1; i < DL; i++) begin
            dlBit[i] <= dlBit[i-1] && !dlKill[i-1];
          end
        end
      end

      always_ff @(posedge clk) begin
        dlTag[0] <= pushSeq;
        for (int i = 1; i < DL; i++) begin
          dlTag[i] <= dlTag[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      credits <= CREDIT_W'(NUM_REGS);
    end else begin
      credits <= credits
                 - (strobes.push ? CREDIT_W'(pushDregs) : '0)
                 + retCredit + retireRegs;
    end
  end

  assign occupancy   = occ;
  assign freeCredits = credits;

endmodule

// File: rtl/lsb_stage_buf.sv
module lsb_stage_buf
  import lsb_pkg::*;
#(
  parameter int LATENCY  = 3,
  parameter int MAX_OCC  = 8,
  parameter int SEQ_W    = 16,
  parameter int DREG_W   = 2,
  parameter int NUM_REGS = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             pushValid,
  input  logic [SEQ_W-1:0]                 pushSeq,
  input  logic [DREG_W-1:0]                pushDregs,
  output logic                             pushReady,
  input  logic                             popReq,
  output logic                             popValid,
  output logic [SEQ_W-1:0]                 popSeq,
  output logic [DREG_W-1:0]                popDregs,
  input  logic                             squashValid,
  input  logic [SEQ_W-1:0]                 squashSeq,
  input  logic                             flush,
  input  logic [$clog2(NUM_REGS+1)-1:0]    retireRegs,
  output logic [$clog2(NUM_REGS+1)-1:0]    freeCredits,
  output logic [$clog2(MAX_OCC+1)-1:0]     occupancy
);

  localparam int CREDIT_W = $clog2(NUM_REGS + 1);
  localparam int OCC_W    = $clog2(MAX_OCC + 1);

  initial begin
    if (LATENCY < 1) $error("LATENCY must be at least 1");
    if ((MAX_OCC < 2) || ((MAX_OCC & (MAX_OCC - 1)) != 0))
      $error("MAX_OCC must be a power of two, at least 2");
  end

  lsbStrobes_t         strobes;
  logic [OCC_W-1:0]    stgCount;
  logic [OCC_W-1:0]    rdyCount;
  logic [CREDIT_W-1:0] retCredit;

  lsb_ctrl #(
    .LATENCY(LATENCY), .MAX_OCC(MAX_OCC), .SEQ_W(SEQ_W), .DREG_W(DREG_W),
    .NUM_REGS(NUM_REGS), .CREDIT_W(CREDIT_W), .OCC_W(OCC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushSeq(pushSeq), .pushDregs(pushDregs),
    .popReq(popReq), .squashValid(squashValid), .squashSeq(squashSeq),
    .flush(flush), .retireRegs(retireRegs),
    .stgCount(stgCount), .rdyCount(rdyCount), .retCredit(retCredit),
    .strobes(strobes), .pushReady(pushReady), .popValid(popValid),
    .occupancy(occupancy), .freeCredits(freeCredits)
  );

  lsb_data #(
    .LATENCY(LATENCY), .DEPTH(MAX_OCC), .SEQ_W(SEQ_W), .DREG_W(DREG_W),
    .CREDIT_W(CREDIT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pushSeq(pushSeq), .pushDregs(pushDregs), .squashSeq(squashSeq),
    .popSeq(popSeq), .popDregs(popDregs),
    .stgCount(stgCount), .rdyCount(rdyCount), .retCredit(retCredit)
  );

endmodule

// File: rtl/lsb_stage_buf_chk.sv
module lsb_stage_buf_chk #(
  parameter int MAX_OCC  = 8,
  parameter int NUM_REGS = 32,
  parameter int CREDIT_W = 6,
  parameter int OCC_W    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                pushReady,
  input logic                popValid,
  input logic                squashValid,
  input logic                flush,
  input logic [CREDIT_W-1:0] freeCredits,
  input logic [OCC_W-1:0]    occupancy
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= OCC_W'(MAX_OCC)); // R4

  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == OCC_W'(MAX_OCC)) |-> !pushReady); // R4

  AST_SQUASH_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid || flush) |=> (occupancy <= $past(occupancy))); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> ((occupancy == '0) && !popValid)); // R7

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeCredits <= CREDIT_W'(NUM_REGS)); // R9

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> (occupancy != '0)); // R10

  AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!squashValid && !flush) |=>
      ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1)); // R10

endmodule

bind lsb_stage_buf lsb_stage_buf_chk #(
  .MAX_OCC(MAX_OCC), .NUM_REGS(NUM_REGS), .CREDIT_W(CREDIT_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pushReady(pushReady), .popValid(popValid),
  .squashValid(squashValid), .flush(flush),
  .freeCredits(freeCredits), .occupancy(occupancy)
);

// File: tb/lsb_stage_buf_tb.sv
`timescale 1ns/1ps
module lsb_stage_buf_tb;

  localparam int LAT      = 3;
  localparam int MAXO     = 8;
  localparam int SEQ_W    = 16;
  localparam int DREG_W   = 2;
  localparam int NREGS    = 12;
  localparam int CREDIT_W = $clog2(NREGS + 1);
  localparam int OCC_W    = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [SEQ_W-1:0] pushSeq = '0;
  logic [DREG_W-1:0] pushDregs = '0;
  logic pushReady;
  logic popReq = 1'b0;
  logic popValid;
  logic [SEQ_W-1:0] popSeq;
  logic [DREG_W-1:0] popDregs;
  logic squashValid = 1'b0;
  logic [SEQ_W-1:0] squashSeq = '0;
  logic flush = 1'b0;
  logic [CREDIT_W-1:0] retireRegs = '0;
  logic [CREDIT_W-1:0] freeCredits;
  logic [OCC_W-1:0] occupancy;

  always #5 clk = ~clk;

  lsb_stage_buf #(
    .LATENCY(LAT), .MAX_OCC(MAXO), .SEQ_W(SEQ_W), .DREG_W(DREG_W),
    .NUM_REGS(NREGS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushSeq(pushSeq),
    .pushDregs(pushDregs), .pushReady(pushReady), .popReq(popReq),
    .popValid(popValid), .popSeq(popSeq), .popDregs(popDregs),
    .squashValid(squashValid), .squashSeq(squashSeq), .flush(flush),
    .retireRegs(retireRegs), .freeCredits(freeCredits), .occupancy(occupancy)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model: one ordered list; each entry knows its maturity cycle.
  int mSeq[$];
  int mDregs[$];
  int mRdy[$];
  int credits = NREGS;
  int outstanding = 0;
  int nextSeq = 5;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit expPushReady(input bit busy, input int pd);
    return !busy && (mSeq.size() < MAXO) && (credits >= pd);
  endfunction

  function automatic bit expPopValid(input bit busy);
    return !busy && (mSeq.size() > 0) && (mRdy[0] <= cyc);
  endfunction

  task automatic step(input bit pv, input int pd, input bit pr, input bit sq,
                      input int ss, input bit fl, input int rt);
    bit busy, eRdy, eVal;
    @(negedge clk);
    pushValid = pv; pushSeq = SEQ_W'(nextSeq); pushDregs = DREG_W'(pd);
    popReq = pr; squashValid = sq; squashSeq = SEQ_W'(ss); flush = fl;
    retireRegs = CREDIT_W'(rt);
    #1;
    busy = sq || fl;
    eRdy = expPushReady(busy, pd);
    eVal = expPopValid(busy);
    check(pushReady == eRdy, "R4/R8/R9 pushReady", int'(pushReady), int'(eRdy));
    check(popValid == eVal, "R2/R8 popValid", int'(popValid), int'(eVal));
    check(int'(occupancy) == mSeq.size(), "R10 occupancy", int'(occupancy), mSeq.size());
    check(int'(freeCredits) == credits, "R6/R9 freeCredits", int'(freeCredits), credits);
    if (eVal && popValid) begin
      check(int'(popSeq) == mSeq[0], "R3 popSeq", int'(popSeq), mSeq[0]);
      check(int'(popDregs) == mDregs[0], "R3 popDregs", int'(popDregs), mDregs[0]);
    end
    // model update for the coming edge
    if (fl) begin
      foreach (mDregs[i]) credits += mDregs[i];
      mSeq.delete(); mDregs.delete(); mRdy.delete();
    end else if (sq) begin
      while (mSeq.size() > 0 && mSeq[mSeq.size()-1] > ss) begin
        credits += mDregs[mDregs.size()-1];
        void'(mSeq.pop_back()); void'(mDregs.pop_back()); void'(mRdy.pop_back());
      end
    end else begin
      if (pr && eVal) begin
        outstanding += mDregs[0];
        void'(mSeq.pop_front()); void'(mDregs.pop_front()); void'(mRdy.pop_front());
      end
      if (pv && eRdy) begin
        mSeq.push_back(nextSeq); mDregs.push_back(pd); mRdy.push_back(cyc + LAT);
        credits -= pd;
        nextSeq += 1 + int'($urandom_range(0, 2));
      end
    end
    credits += rt;
    outstanding -= rt;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(occupancy == '0, "R1 occupancy", int'(occupancy), 0);
    check(!popValid, "R1 popValid", int'(popValid), 0);
    check(pushReady, "R1 pushReady", int'(pushReady), 1);
    check(int'(freeCredits) == NREGS, "R1 freeCredits", int'(freeCredits), NREGS);
    rstN = 1'b1;

    // R2: one entry, watch it mature exactly LAT cycles later
    step(1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < LAT; i++) step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, outstanding);

    // R4: fill to the bound with zero-register entries, then push while full
    for (int i = 0; i < MAXO + 3; i++) step(1, 0, 0, 0, 0, 0, 0);
    idle(LAT);
    // R3: drain in order
    for (int i = 0; i < MAXO + 1; i++) step(0, 0, 1, 0, 0, 0, 0);

    // R5/R6: squash in the middle while entries are split over both queues
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, mSeq[2], 0, 0);
    idle(LAT + 1);
    // R5: squash below every held entry
    step(1, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(2);

    // R7: flush with squash together, pending records in the delay line
    for (int i = 0; i < 4; i++) step(1, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, nextSeq, 1, 0);
    idle(LAT + 1);

    // R9: credit exhaustion, then retire to recover
    for (int i = 0; i < 6; i++) step(1, 3, 0, 0, 0, 0, 0);
    idle(LAT);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, outstanding);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit pv, pr, sq, fl;
      int pd, ss, rt, r;
      pv = ($urandom_range(0, 99) < 70);
      pr = ($urandom_range(0, 99) < 55);
      sq = ($urandom_range(0, 99) < 4);
      fl = ($urandom_range(0, 99) < 1);
      pd = int'($urandom_range(0, 3));
      if (mSeq.size() > 0) begin
        r  = int'($urandom_range(0, mSeq.size() - 1));
        ss = mSeq[r] - int'($urandom_range(0, 1));
      end else begin
        ss = nextSeq;
      end
      rt = (outstanding > 0) ? int'($urandom_range(0, (outstanding < 3) ? outstanding : 3)) : 0;
      step(pv, pd, pr, sq, ss, fl, rt);
    end

    step(0, 0, 0, 0, 0, 1, outstanding);
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule